// File: doc/BRIEF.md
# Page-Bounded Serial DMA Pointer Engine

This block drives the two DMA channels of a serial port, one for transmit and one for receive. Each channel has a pointer register that holds a 32-bit byte address in rotated form: the stored word is the address rotated left by three bit positions. The top three address bits therefore sit in the low three bits of the register. Software loads the pointers and a control/status register through a small register port. Setting a channel enable bit in the control register starts that channel.

A transmit run fetches bytes from memory with sequential reads. It starts at the pointer with its two low bits cleared and stops at the end of the 4 KiB page. Each byte is streamed out on a valid/ready byte interface. At the end of the run the block pulses a page-end event, drops the transmit enable and moves the pointer to the first byte of the next page. While receive is enabled, each byte taken from the serial side is written to memory at the receive pointer, and the pointer then advances by one. A half-page event pulses whenever that advance changes address bit 11. Both channels share one byte-wide memory request port.

Top module: `serial_page_dma`

## Requirements
- R1: The byte address of a channel is its pointer register rotated right by 3 bits. Every pointer the block writes back is the new address rotated left by 3 bits, so bits [2:0] of the register hold address bits [31:29].
- R2: Writing the control register (register index 0) with bit 0 set, while transmit is idle and the page offset (address & 0xFFF) is nonzero, starts a transmit run. The run reads 0x1000 - (address & 0xFFC) bytes at rising addresses, starting at the address with bits [1:0] cleared. It presents each byte, in order, on the transmit stream.
- R3: If the page offset is zero when transmit is started, no memory read is issued, no event pulses, the transmit pointer is unchanged and transmit does not become busy.
- R4: After the last byte of a run is accepted, the block does the following. It pulses tx_page_end for exactly one cycle. It clears the transmit enable (control bit 0). It sets the page-done status (control bit 4). It writes the transmit pointer (register index 1) with the start of the next page, (address | 0xFFF) + 1.
- R5: Any write to the control register clears the page-done status bit 4.
- R6: While receive is enabled (control bit 1), each byte accepted on the receive stream is written to memory at the receive pointer address. The receive pointer (register index 2) then advances by one, and the receive enable stays set.
- R7: rx_half_page pulses for one cycle after a receive write whose pointer advance changes address bit 11. It stays low for any other advance.
- R8: Control bits 2 and 3 read as transmit busy and receive busy. A write to a channel's pointer while that channel is busy is ignored.
- R9: After reset, every register reads zero, no memory request is made, no event is raised and the receive stream is not ready.
- R10: A memory request that is not accepted keeps its valid, address and direction unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 transmit pointer, 2 receive pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Serial side takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block takes the receive byte |
| rx_data | input | 8 | Receive byte |
| tx_page_end | output | 1 | One-cycle transmit page-end event |
| rx_half_page | output | 1 | One-cycle receive half-page event |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 4 KiB page and a rotation of three. With these values a full 4096-byte transmit page fits within the run, as do short runs of four bytes at the page tail. Pointers with the top address bits set exercise the rotated storage. Memory and transmit readiness are held low on some cycles, so requests must wait under back-pressure. Receive pointers placed just below 0x800 and just below a page boundary make bit 11 change in both directions.

// File: rtl/serial_page_dma.sv
module serial_page_dma #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTR_ROT   = 3,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_page_end,
  output logic              rx_half_page
);

  localparam int LEN_W = PAGE_BITS + 1;
  localparam logic [LEN_W-1:0]  PAGE_BYTES = {1'b1, {PAGE_BITS{1'b0}}};
  localparam logic [ADDR_W-1:0] PAGE_MASK  = {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};
  localparam int HALF_BIT = PAGE_BITS - 1;

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_WAIT, TX_OUT} tx_st_t;
  typedef enum logic {RX_IDLE, RX_WR} rx_st_t;

  function automatic logic [ADDR_W-1:0] ptr2addr(input logic [ADDR_W-1:0] p);
    return {p[PTR_ROT-1:0], p[ADDR_W-1:PTR_ROT]};
  endfunction

  function automatic logic [ADDR_W-1:0] addr2ptr(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-PTR_ROT-1:0], a[ADDR_W-1:ADDR_W-PTR_ROT]};
  endfunction

  tx_st_t            tx_state;
  rx_st_t            rx_state;
  logic              tx_en, rx_en, tx_done, hold_rx;
  logic [ADDR_W-1:0] tx_ptr, rx_ptr, tx_cur;
  logic [LEN_W-1:0]  tx_left;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  logic              tx_busy, rx_busy, grant_rx, grant_tx, csr_we;
  logic [ADDR_W-1:0] tx_base, rx_addr, rx_next, tx_next;
  logic [PAGE_BITS-1:0] tx_off;
  logic [LEN_W-1:0]  tx_len;

  assign tx_busy  = (tx_state != TX_IDLE);
  assign rx_busy  = (rx_state == RX_WR);
  assign csr_we   = reg_we && (reg_addr == 2'd0);

  assign tx_base  = ptr2addr(tx_ptr);
  assign tx_off   = tx_base[PAGE_BITS-1:0];
  assign tx_len   = PAGE_BYTES - LEN_W'({tx_off[PAGE_BITS-1:2], 2'b00});
  assign tx_next  = (tx_cur | PAGE_MASK) + ADDR_W'(1);
  assign rx_addr  = ptr2addr(rx_ptr);
  assign rx_next  = rx_addr + ADDR_W'(1);

  assign grant_rx = rx_busy && (hold_rx || tx_state != TX_REQ);
  assign grant_tx = (tx_state == TX_REQ) && !grant_rx;

  assign mem_req_valid = grant_rx || grant_tx;
  assign mem_req_write = grant_rx;
  assign mem_addr      = grant_rx ? rx_addr : tx_cur;
  assign mem_wdata     = rx_byte;

  assign tx_valid = (tx_state == TX_OUT);
  assign tx_data  = tx_byte;
  assign rx_ready = rx_en && (rx_state == RX_IDLE);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ADDR_W'({tx_done, rx_busy, tx_busy, rx_en, tx_en});
      2'd1:    reg_rdata = tx_ptr;
      2'd2:    reg_rdata = rx_ptr;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_state     <= TX_IDLE;
      rx_state     <= RX_IDLE;
      tx_en        <= 1'b0;
      rx_en        <= 1'b0;
      tx_done      <= 1'b0;
      hold_rx      <= 1'b0;
      tx_ptr       <= '0;
      rx_ptr       <= '0;
      tx_cur       <= '0;
      tx_left      <= '0;
      tx_byte      <= '0;
      rx_byte      <= '0;
      tx_page_end  <= 1'b0;
      rx_half_page <= 1'b0;
    end else begin
      tx_page_end  <= 1'b0;
      rx_half_page <= 1'b0;
      hold_rx      <= grant_rx && !mem_req_ready;

      if (csr_we) begin
        tx_done <= 1'b0;
        rx_en   <= reg_wdata[1];
        if (!tx_busy) begin
          tx_en <= reg_wdata[0];
          if (reg_wdata[0] && tx_off != '0) begin
            tx_state <= TX_REQ;
            tx_cur   <= {tx_base[ADDR_W-1:2], 2'b00};
            tx_left  <= tx_len;
          end
        end
      end
      if (reg_we && reg_addr == 2'd1 && !tx_busy) tx_ptr <= reg_wdata;
      if (reg_we && reg_addr == 2'd2 && !rx_busy) rx_ptr <= reg_wdata;

      case (tx_state)
        TX_REQ:  if (grant_tx && mem_req_ready) tx_state <= TX_WAIT;
        TX_WAIT: if (mem_rsp_valid) begin
                   tx_byte  <= mem_rsp_data;
                   tx_state <= TX_OUT;
                 end
        TX_OUT:  if (tx_ready) begin
                   if (tx_left == LEN_W'(1)) begin
                     tx_state    <= TX_IDLE;
                     tx_en       <= 1'b0;
                     tx_ptr      <= addr2ptr(tx_next);
                     tx_page_end <= 1'b1;
                     tx_done     <= 1'b1;
                   end else begin
                     tx_cur   <= tx_cur + ADDR_W'(1);
                     tx_left  <= tx_left - LEN_W'(1);
                     tx_state <= TX_REQ;
                   end
                 end
        default: ;
      endcase

      case (rx_state)
        RX_IDLE: if (rx_valid && rx_ready) begin
                   rx_byte  <= rx_data;
                   rx_state <= RX_WR;
                 end
        RX_WR:   if (grant_rx && mem_req_ready) begin
                   rx_ptr       <= addr2ptr(rx_next);
                   rx_half_page <= rx_addr[HALF_BIT] ^ rx_next[HALF_BIT];
                   rx_state     <= RX_IDLE;
                 end
        default: ;
      endcase
    end
  end

endmodule

module serial_page_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_page_end,
  input logic              rx_half_page,
  input logic              tx_en,
  input logic              tx_busy,
  input logic              tx_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_addr
);

  // R4
  tx_pe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_page_end |=> !tx_page_end);

  // R4
  tx_pe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_page_end |-> (!tx_en && !tx_busy));

  // R7
  rx_half_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_half_page |-> $past(mem_req_valid && mem_req_ready && mem_req_write));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_req_write)));

  // R2
  tx_stream_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_busy);

endmodule

bind serial_page_dma serial_page_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_page_end(tx_page_end), .rx_half_page(rx_half_page),
  .tx_en(tx_en), .tx_busy(tx_busy), .tx_valid(tx_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_addr(mem_addr)
);

// File: tb/serial_page_dma_tb.sv
module serial_page_dma_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write, mem_req_ready;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_page_end, rx_half_page;

  int tests = 0, fails = 0;
  int cyc = 0, rd_cnt = 0, wr_cnt = 0, tx_cnt = 0, bad_cnt = 0, pe_cnt = 0, half_cnt = 0;
  int tx_cnt0 = 0;
  logic [31:0] tx_first = '0, wr_last_addr = '0;
  logic [7:0]  wr_last_data = '0;

  always #10 clk = ~clk;

  serial_page_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_page_end(tx_page_end), .rx_half_page(rx_half_page)
  );

  function automatic logic [7:0] mdl(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] enc(input logic [31:0] a);
    return {a[28:0], a[31:29]};
  endfunction

  assign mem_req_ready = (cyc % 4) != 3;
  assign tx_ready      = (cyc % 8) != 5;

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
    mem_rsp_data  <= mdl(mem_addr);
    if (mem_req_valid && mem_req_ready && !mem_req_write) rd_cnt <= rd_cnt + 1;
    if (mem_req_valid && mem_req_ready && mem_req_write) begin
      wr_cnt       <= wr_cnt + 1;
      wr_last_addr <= mem_addr;
      wr_last_data <= mem_wdata;
    end
    if (tx_valid && tx_ready) begin
      tx_cnt <= tx_cnt + 1;
      if (tx_data != mdl(tx_first + 32'(tx_cnt - tx_cnt0))) bad_cnt <= bad_cnt + 1;
    end
    if (tx_page_end) pe_cnt <= pe_cnt + 1;
    if (rx_half_page) half_cnt <= half_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_tx_idle();
    logic [31:0] v;
    for (int i = 0; i < 40000; i++) begin
      rd(2'd0, v);
      if (!v[2]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk);
    rx_data = d; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // {pointer address, expected transmit length}
  localparam logic [63:0] TXV [6] = '{
    {32'h0000_1F00, 32'd256},
    {32'h0000_2FFC, 32'd4},
    {32'h0000_3FFE, 32'd4},
    {32'h8000_0F80, 32'd128},
    {32'hE000_4001, 32'd4096},
    {32'hA000_0801, 32'd2048}
  };

  initial begin
    repeat (180000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0, b0, p0, r0, h0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(2'd0, v); check(v == 0, "R9", "control", v, 0);
    rd(2'd1, v); check(v == 0, "R9", "tx pointer", v, 0);
    rd(2'd2, v); check(v == 0, "R9", "rx pointer", v, 0);
    check(!mem_req_valid, "R9", "mem request", mem_req_valid, 0);
    check(!tx_page_end && !rx_half_page, "R9", "events", {tx_page_end, rx_half_page}, 0);
    check(!rx_ready, "R9", "rx ready", rx_ready, 0);

    // R2 R4 R1 R10 table of transmit runs
    foreach (TXV[k]) begin
      logic [31:0] a, n, len;
      a = TXV[k][63:32]; len = TXV[k][31:0];
      n = (a | 32'hFFF) + 32'd1;
      wr(2'd1, enc(a));
      c0 = tx_cnt; b0 = bad_cnt; p0 = pe_cnt; r0 = rd_cnt;
      tx_cnt0 = tx_cnt; tx_first = a & ~32'd3;
      wr(2'd0, 32'd1);
      wait_tx_idle();
      check(tx_cnt - c0 == int'(len), "R2", "bytes streamed", tx_cnt - c0, len);
      check(rd_cnt - r0 == int'(len), "R10", "reads accepted", rd_cnt - r0, len);
      check(bad_cnt == b0, "R2", "byte order/address", bad_cnt - b0, 0);
      check(pe_cnt - p0 == 1, "R4", "page-end pulses", pe_cnt - p0, 1);
      rd(2'd1, v); check(v == enc(n), "R1", "tx pointer after run", v, enc(n));
      rd(2'd0, v); check(v[4:0] == 5'b10000, "R4", "control after run", v[4:0], 5'b10000);
    end

    // R5 control write clears page-done
    wr(2'd0, 32'd0);
    rd(2'd0, v); check(v[4] == 1'b0, "R5", "page-done after write", v[4], 0);

    // R3 zero page offset
    wr(2'd1, enc(32'h0000_5000));
    r0 = rd_cnt; p0 = pe_cnt;
    wr(2'd0, 32'd1);
    repeat (20) @(negedge clk);
    check(rd_cnt == r0, "R3", "reads", rd_cnt - r0, 0);
    check(pe_cnt == p0, "R3", "page-end", pe_cnt - p0, 0);
    rd(2'd1, v); check(v == enc(32'h5000), "R3", "pointer", v, enc(32'h5000));
    rd(2'd0, v); check(v[2] == 1'b0, "R3", "busy", v[2], 0);
    wr(2'd0, 32'd0);

    // R8 pointer write during busy transmit
    wr(2'd1, enc(32'h0000_7004));
    tx_cnt0 = tx_cnt; tx_first = 32'h7004;
    wr(2'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(2'd0, v); check(v[2] == 1'b1, "R8", "tx busy", v[2], 1);
    wr(2'd1, enc(32'h1234_5678));
    rd(2'd1, v); check(v == enc(32'h7004), "R8", "ignored pointer write", v, enc(32'h7004));
    wait_tx_idle();
    rd(2'd1, v); check(v == enc(32'h8000), "R8", "pointer after run", v, enc(32'h8000));

    // R6 R7 receive across 0x800
    wr(2'd2, enc(32'h0000_07FE));
    wr(2'd0, 32'd2);
    w0 = wr_cnt; h0 = half_cnt;
    rx_send(8'h11); rx_send(8'h22); rx_send(8'h33); rx_send(8'h44);
    check(wr_cnt - w0 == 4, "R6", "writes", wr_cnt - w0, 4);
    check(wr_last_addr == 32'h801, "R6", "last write address", wr_last_addr, 32'h801);
    check(wr_last_data == 8'h44, "R6", "last write data", wr_last_data, 8'h44);
    check(half_cnt - h0 == 1, "R7", "half events at 0x800", half_cnt - h0, 1);
    rd(2'd2, v); check(v == enc(32'h802), "R6", "rx pointer", v, enc(32'h802));
    rd(2'd0, v); check(v[1] == 1'b1, "R6", "rx enable kept", v[1], 1);

    // R7 across page boundary, then no crossing
    wr(2'd2, enc(32'h0000_1FFF));
    h0 = half_cnt;
    rx_send(8'h55);
    check(half_cnt - h0 == 1, "R7", "half event at page end", half_cnt - h0, 1);
    rx_send(8'h66);
    check(half_cnt - h0 == 1, "R7", "no event without change", half_cnt - h0, 1);
    rd(2'd2, v); check(v == enc(32'h2001), "R7", "rx pointer", v, enc(32'h2001));

    // R1 top address bits through rotated receive pointer
    wr(2'd2, enc(32'hC000_0100));
    rx_send(8'h77);
    check(wr_last_addr == 32'hC000_0100, "R1", "rotated write address", wr_last_addr, 32'hC000_0100);
    rd(2'd2, v); check(v == enc(32'hC000_0101), "R1", "rotated write-back", v, enc(32'hC000_0101));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule